// File: doc/BRIEF.md
# Split-Read Wide Cycle Counter with Coherence Status

This block holds a free-running cycle counter that is twice as wide as the processor's register port. Software cannot read it in one access, so it reads the lower half, then the upper half, then a control/status register. The block does not capture a copy of the upper half. A small tracker watches the two data reads and records whether the pair is coherent. A pair is coherent only if no interrupt or exception was taken while it was in progress and the upper half did not move after the lower half was sampled. Software repeats the three reads until the status bit says the pair is good.

The counter half width is a parameter: 32 bits by default, giving a 64-bit count. Register data is always 32 bits wide, and a half narrower than 32 bits reads back zero-extended. An interrupt or exception strobe from outside the block is an input. Reads return data in the same cycle as the read strobe. The tracker updates on the clock edge that ends the read cycle.

Top module: `ctr_split_read_top`

## Requirements
- R1: After reset the counter is zero, the enable is clear and the status bit (bit 31 of the control register) reads 0.
- R2: A write to address 0x103 loads the enable from data bit 0. A read of 0x103 returns the enable in bit 0, the status in bit 31, and zero in bits 30:1.
- R3: A read of 0x104 returns the lower counter half and a read of 0x105 returns the upper half, both zero-extended to 32 bits. A read of any other address returns zero.
- R4: While enabled, the counter rises by one on every clock and wraps to zero after its maximum. While disabled, it holds its value.
- R5: A low read followed by a high read sets the status bit when no trap occurred and no carry reached the upper half in between. The upper half read is then the counter's upper half at the moment of the low read.
- R6: The pair is marked bad if the trap input is high in any cycle from the low read up to and including the high read.
- R7: The pair is marked bad if a carry leaves the lower half on any clock edge from the one ending the low-read cycle up to the one before the high-read cycle. This holds even when the high read comes in the very next cycle.
- R8: A high read with no low read pending leaves the status bit clear.
- R9: A low read always re-arms the tracker and discards any earlier trap or carry record. Control reads and idle cycles between the low and high reads do not disturb the tracker.
- R10: Once a pair has finished, the status bit holds its value until the next low or high read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 32 | Write data |
| trap_taken | input | 1 | High in a cycle in which an interrupt or exception is taken |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |

## Verification
The bench uses a 4-bit half, so every lower-half phase and every wrap of the upper half comes up within a few hundred cycles. It sweeps read pairs with one to three cycles between the low and high reads, which separates a carry on the first edge, on a middle edge, and on the high-read edge (the last of these is harmless). Trap pulses are placed at each position from the low-read cycle to the high-read cycle, and also after the pair, so that a trap inside the window can be told apart from one outside it. Separate passes cover a stray high read, a low read that re-arms after a spoiled one, control reads in the middle of a pair, a disabled counter, and a retry loop whose final value must be self-consistent.

// File: rtl/ctr_split_pkg.sv
package ctr_split_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 12'h103;
  localparam logic [ADDR_W-1:0] ADDR_LOW  = 12'h104;
  localparam logic [ADDR_W-1:0] ADDR_HIGH = 12'h105;
  localparam int STATUS_BIT = REG_W - 1;

  typedef enum logic [1:0] {
    TRK_IDLE  = 2'd0,
    TRK_ARMED = 2'd1,
    TRK_GOOD  = 2'd2,
    TRK_BAD   = 2'd3
  } trk_state_e;

  // Outcome of a finished pair: good only from the armed state with a clean record.
  function automatic trk_state_e pair_outcome(input trk_state_e cur,
                                              input logic tainted,
                                              input logic trap_now);
    if (cur != TRK_ARMED)        return TRK_IDLE;
    else if (tainted || trap_now) return TRK_BAD;
    else                          return TRK_GOOD;
  endfunction
endpackage

// File: rtl/ctr_split_counter.sv
module ctr_split_counter #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             carry_o
);
  logic [CNT_W-1:0] cnt_q;

  // Carry into the upper half happens on this edge when the lower half is full.
  assign carry_o = en_i && (cnt_q[HALF_W-1:0] == {HALF_W{1'b1}});
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> cnt_q == $past(cnt_q) + 1'b1);
  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_q));
  // R7
  carry_moves_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |=> cnt_q[CNT_W-1:HALF_W] != $past(cnt_q[CNT_W-1:HALF_W]));
endmodule

// File: rtl/ctr_split_regif.sv
module ctr_split_regif
  import ctr_split_pkg::*;
#(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              status_i,
  output logic              en_o,
  output logic              lo_rd_o,
  output logic              hi_rd_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic en_q;
  logic ctrl_wr;
  logic ctrl_rd;
  logic [REG_W-1:0] lo_ext;
  logic [REG_W-1:0] hi_ext;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign ctrl_rd = reg_rd && (reg_addr == ADDR_CTRL);
  assign lo_rd_o = reg_rd && (reg_addr == ADDR_LOW);
  assign hi_rd_o = reg_rd && (reg_addr == ADDR_HIGH);
  assign en_o    = en_q;

  always_comb begin
    lo_ext = '0;
    hi_ext = '0;
    lo_ext[HALF_W-1:0] = cnt_i[HALF_W-1:0];
    hi_ext[HALF_W-1:0] = cnt_i[CNT_W-1:HALF_W];
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_rd) begin
      rdata_o[0]          = en_q;
      rdata_o[STATUS_BIT] = status_i;
    end else if (lo_rd_o) begin
      rdata_o = lo_ext;
    end else if (hi_rd_o) begin
      rdata_o = hi_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (ctrl_wr) en_q <= reg_wdata[0];
  end

  // R2
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> en_q == $past(reg_wdata[0]));
  // R2
  enable_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(en_q));
endmodule

// File: rtl/ctr_split_tracker.sv
module ctr_split_tracker
  import ctr_split_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lo_rd_i,
  input  logic hi_rd_i,
  input  logic carry_i,
  input  logic trap_i,
  output logic status_o
);
  trk_state_e state_q;
  logic       taint_q;
  logic       armed;

  assign armed    = (state_q == TRK_ARMED);
  assign status_o = (state_q == TRK_GOOD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TRK_IDLE;
      taint_q <= 1'b0;
    end else if (lo_rd_i) begin
      state_q <= TRK_ARMED;
      taint_q <= carry_i || trap_i;
    end else if (hi_rd_i) begin
      state_q <= pair_outcome(state_q, taint_q, trap_i);
      taint_q <= 1'b0;
    end else if (armed) begin
      taint_q <= taint_q || carry_i || trap_i;
    end
  end

  // R5
  good_after_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o) |-> $past(hi_rd_i) && $past(armed));
  // R6
  trap_spoils_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && trap_i && !lo_rd_i) |=> !status_o);
  // R7
  carry_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && carry_i && !lo_rd_i && !hi_rd_i) |=> armed && taint_q);
  // R8
  stray_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rd_i && !armed) |=> state_q == TRK_IDLE);
  // R9
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd_i |=> armed);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_rd_i && !hi_rd_i && !armed) |=> $stable(state_q));
endmodule

// File: rtl/ctr_split_read_top.sv
module ctr_split_read_top
  import ctr_split_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        trap_taken,
  output logic [31:0] reg_rdata
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] cnt;
  logic             carry;
  logic             en;
  logic             lo_rd;
  logic             hi_rd;
  logic             status;

  ctr_split_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en_i(en), .cnt_o(cnt), .carry_o(carry)
  );

  ctr_split_regif #(.HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cnt_i(cnt),
    .status_i(status), .en_o(en), .lo_rd_o(lo_rd), .hi_rd_o(hi_rd),
    .rdata_o(reg_rdata)
  );

  ctr_split_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .lo_rd_i(lo_rd), .hi_rd_i(hi_rd),
    .carry_i(carry), .trap_i(trap_taken), .status_o(status)
  );
endmodule

// File: tb/tb_ctr_split_read_top.sv
module tb_ctr_split_read_top;
  localparam int HW = 4;
  localparam logic [11:0] A_CTRL = 12'h103, A_LO = 12'h104, A_HI = 12'h105;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_rd = 1'b0, reg_wr = 1'b0, trap_taken = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference: counter value and enable as the requirements define them.
  logic [2*HW-1:0] m_cnt = '0;
  logic m_en = 1'b0;

  ctr_split_read_top #(.HALF_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .trap_taken(trap_taken),
    .reg_rdata(reg_rdata)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0; m_en <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) m_en <= reg_wdata[0];
      if (m_en) m_cnt <= m_cnt + 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, sample shortly after.
  task automatic cyc(input logic rd, input logic [11:0] a, input logic tr,
                     output logic [31:0] d, output logic [2*HW-1:0] mc);
    @(negedge clk);
    reg_rd = rd; reg_wr = 1'b0; reg_addr = a; trap_taken = tr;
    #1; d = reg_rdata; mc = m_cnt;
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b0; reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = v; trap_taken = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Low read, gap-1 filler cycles, high read, then a control read.
  // trap_at: cycle index relative to the low read (-1 none); filler: 1 = control read.
  task automatic pair(input int gap, input int trap_at, input bit filler,
                      output logic [31:0] lo, output logic [31:0] hi,
                      output logic [31:0] ctl, output logic [2*HW-1:0] m_at_lo);
    logic [31:0] d; logic [2*HW-1:0] mc;
    for (int c = 0; c <= gap; c++) begin
      if (c == 0)        cyc(1'b1, A_LO, trap_at == c, d, mc);
      else if (c == gap) cyc(1'b1, A_HI, trap_at == c, d, mc);
      else               cyc(filler, filler ? A_CTRL : 12'h000, trap_at == c, d, mc);
      if (c == 0) begin lo = d; m_at_lo = mc; end
      if (c == gap) hi = d;
    end
    cyc(1'b1, A_CTRL, trap_at == gap + 1, ctl, mc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, lo, hi, ctl;
    logic [2*HW-1:0] mc, m0;
    int exp_bad;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    cyc(1'b1, A_CTRL, 1'b0, d, mc); chk("R1 ctrl after reset", d, 32'h0);
    cyc(1'b1, A_LO, 1'b0, d, mc);   chk("R1 low after reset", d, 32'h0);
    cyc(1'b1, A_HI, 1'b0, d, mc);   chk("R1 high after reset", d, 32'h0);
    // R8 that high read had no pending low read... but a low read preceded it; re-check stray below.

    // R3 unmapped address reads zero
    cyc(1'b1, 12'h106, 1'b0, d, mc); chk("R3 unmapped read", d, 32'h0);

    // R2 enable, upper bits written as ones read zero
    wr_ctrl(32'hFFFF_FFFF);
    cyc(1'b1, A_CTRL, 1'b0, d, mc); chk("R2 ctrl readback", d & 32'h7FFF_FFFF, 32'h1);

    // R4 counting matches reference each cycle
    for (int i = 0; i < 40; i++) begin
      cyc(1'b1, (i % 2) ? A_HI : A_LO, 1'b0, d, mc);
      chk("R4 R3 counter half", d, (i % 2) ? {28'h0, mc[2*HW-1:HW]} : {28'h0, mc[HW-1:0]});
    end

    // R5 R6 R7 sweep: gaps, trap positions, filler kind, all low-half phases
    for (int i = 0; i < 180; i++) begin
      int gap = (i % 3) + 1;
      int tat = ((i / 3) % 6) - 1;
      bit fil = (i / 18) % 2;
      pair(gap, tat, fil, lo, hi, ctl, m0);
      chk("R3 low value", lo, {28'h0, m0[HW-1:0]});
      exp_bad = ((lo + gap) > 15) ? 1 : 0;           // R7 carry within window
      if (tat >= 0 && tat <= gap) exp_bad = 1;         // R6 trap within window
      chk(exp_bad ? "R6 R7 bad pair status" : "R5 good pair status",
          {31'h0, ctl[31]}, {31'h0, exp_bad == 0});
      if (!exp_bad) chk("R5 coherent high", hi, {28'h0, m0[2*HW-1:HW]});
      // R10 status persists through further control reads
      cyc(1'b1, A_CTRL, 1'b0, d, mc);
      chk("R10 status held", {31'h0, d[31]}, {31'h0, exp_bad == 0});
      for (int k = 0; k < (i % 4); k++) cyc(1'b0, 12'h0, 1'b0, d, mc);
    end

    // R8 stray high read after a completed pair
    cyc(1'b1, A_HI, 1'b0, d, mc);
    cyc(1'b1, A_CTRL, 1'b0, d, mc); chk("R8 stray high", {31'h0, d[31]}, 32'h0);

    // R9 re-arm: spoiled low read, then clean low/high
    do cyc(1'b1, A_LO, 1'b1, d, mc); while (d[3:0] > 4'd11);
    cyc(1'b1, A_LO, 1'b0, d, mc);
    cyc(1'b1, A_HI, 1'b0, d, mc);
    cyc(1'b1, A_CTRL, 1'b0, d, mc); chk("R9 rearm clears trap record", {31'h0, d[31]}, 32'h1);

    // R4 disabled: counter holds, pairs always good
    wr_ctrl(32'h0);
    cyc(1'b1, A_LO, 1'b0, lo, m0);
    repeat (5) cyc(1'b0, 12'h0, 1'b0, d, mc);
    cyc(1'b1, A_LO, 1'b0, d, mc); chk("R4 hold low", d, lo);
    cyc(1'b1, A_HI, 1'b0, d, mc); chk("R4 hold high", d, {28'h0, m0[2*HW-1:HW]});
    cyc(1'b1, A_CTRL, 1'b0, d, mc); chk("R2 R5 disabled ctrl", d, 32'h8000_0000);

    // R5 software retry loop ending in a self-consistent value
    wr_ctrl(32'h1);
    begin
      int tries = 0;
      do begin
        pair(1, (tries == 0) ? 0 : -1, 1'b0, lo, hi, ctl, m0);
        tries++;
      end while (!ctl[31] && tries < 4);
      chk("R5 retry converges", {31'h0, ctl[31]}, 32'h1);
      chk("R5 retry value", {hi[3:0], lo[3:0]}, {24'h0, m0});
      chk("R6 first attempt spoiled", tries, 2);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule